// File: doc/BRIEF.md
# SDRAM Command Timing Interlock

This block sits between an SDRAM command sequencer and the memory command pins. It accepts one requested command at a time (NOP, activate, read, write, precharge, refresh, self-refresh entry, self-refresh exit) over a valid/ready handshake. It holds a command back until every spacing constraint that applies to it has elapsed. While a command is held, the pins carry NOP. Accepted commands appear on the registered pins one clock later.

The minimum spacings come from a single programmable configuration word:

- Five 4-bit cycle counts, each with a floor of two clocks: write-to-precharge recovery, refresh-to-activate, precharge-to-next, activate-to-column and activate-to-precharge.
- A 5-bit self-refresh exit delay counted in half clocks.
- A 2-bit CAS latency code. It is reported to the read-data capture logic as a cycle count.

Each constraint is tracked by a down-counter. The counter is loaded when its starting command issues. When a new load meets a counter that is still running, the counter keeps the larger of the two values.

Top module: `sdram_cmd_interlock`

## Requirements
- R1: After reset the pins carry NOP (`111`) with clock enable high, `cfg_err` is 0, `rd_latency` is 2, and the timing fields hold write recovery 2, refresh-to-activate 8, precharge 3, activate-to-column 3, activate-to-precharge 5 and exit delay 10 half clocks.
- R2: Request codes on `req_cmd` are 0 NOP, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 self-refresh entry and 7 self-refresh exit. A command is taken on a clock edge where `req_valid` and `req_ready` are both high. In the next cycle `pin_cmd` = {row strobe, column strobe, write enable} shows activate `011`, read `101`, write `100`, precharge `010`, refresh `001`, self-refresh entry `001` with clock enable low, and NOP or exit as `111`. In every other cycle `pin_cmd` is `111`.
- R3: A read or write is accepted no sooner than the activate-to-column count of cycles after the last activate.
- R4: A precharge is accepted no sooner than the activate-to-precharge count after the last activate.
- R5: After a precharge, no activate, read, write, precharge, refresh or self-refresh entry is accepted for the precharge count of cycles.
- R6: An activate is accepted no sooner than the refresh-to-activate count after the last refresh.
- R7: A precharge is accepted no sooner than the write recovery count after the last write. A write's single data cycle coincides with its command.
- R8: Any of the five cycle fields programmed to 0, 1 or 2 enforces exactly two cycles.
- R9: After a self-refresh exit, an activate waits max(1, ceil(h/2)) cycles, where h is the 5-bit half-clock field.
- R10: Self-refresh entry drives clock enable low. Until an exit is taken, only NOP and exit are ready. The exit raises clock enable. An exit outside self-refresh has no effect and starts no delay.
- R11: A configuration write whose CAS code (bits 26:25) is `10` sets `rd_latency` to 2 and clears `cfg_err`. Any other code sets `cfg_err` and leaves the latency unchanged. The timing fields are updated by every write. Word layout: bits 3:0 write recovery, 7:4 refresh-to-activate, 11:8 precharge, 15:12 activate-to-column, 19:16 activate-to-precharge, 24:20 exit half clocks.
- R12: When several constraints gate one command, it waits for the latest one to expire. A configuration change affects only delays started after the edge on which it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_word | input | 27 | Configuration word |
| cfg_err | output | 1 | Last configuration write had a reserved CAS code |
| rd_latency | output | 2 | CAS latency in cycles for read capture |
| req_valid | input | 1 | Command request valid |
| req_cmd | input | 3 | Requested command code |
| req_ready | output | 1 | Requested command may issue this cycle |
| pin_cmd | output | 3 | Registered row strobe, column strobe, write enable |
| pin_cke | output | 1 | Registered memory clock enable |

## Verification
The hardest situation to reach is a precharge gated by two timers at once: the activate-to-precharge window from an earlier activate and the write recovery from a later write, with the activate window expiring last. The stimulus places an activate, then a write at the earliest legal cycle, with a long activate-to-precharge setting and a short recovery, so the precharge must follow the older timer. Random traffic with random configuration rewrites, including reserved CAS codes and out-of-range fields, then runs against a cycle-accurate bench model. That mix creates configuration changes while timers are in flight and long stays in self-refresh.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  localparam int DLY_W = 4;
  localparam int XSR_W = 5;
  localparam int NT    = 6;

  localparam int T_WR  = 0;
  localparam int T_RC  = 1;
  localparam int T_RP  = 2;
  localparam int T_RCD = 3;
  localparam int T_RAS = 4;
  localparam int T_XSR = 5;

  typedef enum logic [2:0] {
    C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
    C_PRE = 3'd4, C_REF = 3'd5, C_SRE = 3'd6, C_SRX = 3'd7
  } cmd_e;

  typedef struct packed {
    logic [1:0]       cas;
    logic [XSR_W-1:0] xsr;
    logic [DLY_W-1:0] ras;
    logic [DLY_W-1:0] rcd;
    logic [DLY_W-1:0] rp;
    logic [DLY_W-1:0] rc;
    logic [DLY_W-1:0] wr;
  } cfg_t;

  localparam int   CFGW      = $bits(cfg_t);
  localparam logic [1:0] CAS_TWO = 2'b10;
  localparam cfg_t CFG_RESET = '{cas: CAS_TWO, xsr: 5'd10, ras: 4'd5,
                                 rcd: 4'd3, rp: 4'd3, rc: 4'd8, wr: 4'd2};
  localparam logic [2:0] PIN_NOP = 3'b111;

  function automatic logic [DLY_W-1:0] clamp_cyc(input logic [DLY_W-1:0] f);
    return (f < DLY_W'(2)) ? DLY_W'(2) : f;
  endfunction

  function automatic logic [XSR_W-1:0] xsr_cyc(input logic [XSR_W-1:0] h);
    logic [XSR_W:0] up;
    up = ({1'b0, h} + 1'b1) >> 1;
    return (h == '0) ? XSR_W'(1) : up[XSR_W-1:0];
  endfunction

  function automatic logic cas_ok(input logic [1:0] code);
    return code == CAS_TWO;
  endfunction

  function automatic logic [1:0] cas_cycles(input logic [1:0] code);
    return cas_ok(code) ? 2'd2 : 2'd0;
  endfunction

  function automatic logic [2:0] pin_code(input cmd_e c);
    case (c)
      C_ACT:         return 3'b011;
      C_RD:          return 3'b101;
      C_WR:          return 3'b100;
      C_PRE:         return 3'b010;
      C_REF, C_SRE:  return 3'b001;
      default:       return PIN_NOP;
    endcase
  endfunction

  function automatic logic [NT-1:0] gate_mask(input cmd_e c);
    logic [NT-1:0] m;
    m = '0;
    case (c)
      C_ACT: begin m[T_RC] = 1'b1; m[T_RP] = 1'b1; m[T_XSR] = 1'b1; end
      C_RD, C_WR: begin m[T_RCD] = 1'b1; m[T_RP] = 1'b1; end
      C_PRE: begin m[T_RAS] = 1'b1; m[T_WR] = 1'b1; m[T_RP] = 1'b1; end
      C_REF, C_SRE: m[T_RP] = 1'b1;
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [NT-1:0] start_mask(input cmd_e c, input logic sr);
    logic [NT-1:0] m;
    m = '0;
    case (c)
      C_ACT: begin m[T_RCD] = 1'b1; m[T_RAS] = 1'b1; end
      C_WR:  m[T_WR] = 1'b1;
      C_PRE: m[T_RP] = 1'b1;
      C_REF: m[T_RC] = 1'b1;
      C_SRX: m[T_XSR] = sr;
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sdi_cfg_reg.sv
module sdi_cfg_reg
  import sdi_pkg::*;
#(
  parameter int CFG_W = CFGW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  output cfg_t             cfg_q,
  output logic             cfg_err,
  output logic [1:0]       rd_latency
);
  cfg_t incoming;
  logic code_ok;

  always_comb begin
    incoming = cfg_t'(cfg_word);
    code_ok  = cas_ok(incoming.cas);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      cfg_err <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q.wr  <= incoming.wr;
      cfg_q.rc  <= incoming.rc;
      cfg_q.rp  <= incoming.rp;
      cfg_q.rcd <= incoming.rcd;
      cfg_q.ras <= incoming.ras;
      cfg_q.xsr <= incoming.xsr;
      if (code_ok) cfg_q.cas <= incoming.cas;
      cfg_err <= !code_ok;
    end
  end

  assign rd_latency = cas_cycles(cfg_q.cas);
endmodule

// File: rtl/sdi_timer.sv
module sdi_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt, dec, nxt;

  always_comb begin
    dec = (cnt == '0) ? '0 : cnt - 1'b1;
    nxt = (load && load_val > dec) ? load_val : dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sdi_gate.sv
module sdi_gate
  import sdi_pkg::*;
#(
  parameter int N = NT,
  parameter int W = DLY_W
) (
  input  logic                req_valid,
  input  logic [2:0]          req_cmd,
  input  logic                in_sr,
  input  logic [N-1:0]        t_zero,
  input  cfg_t                cfg,
  output logic                req_ready,
  output logic                issue,
  output logic [N-1:0]        t_load,
  output logic [N-1:0][W-1:0] t_val
);
  cmd_e          cmd;
  logic          sr_block;
  logic [N-1:0]  need;
  logic [XSR_W-1:0] xsr_m1;

  always_comb begin
    cmd       = cmd_e'(req_cmd);
    sr_block  = in_sr && !(cmd == C_NOP || cmd == C_SRX);
    need      = gate_mask(cmd);
    req_ready = !sr_block && ((need & ~t_zero) == '0);
    issue     = req_valid && req_ready;
    t_load    = issue ? start_mask(cmd, in_sr) : '0;
    xsr_m1    = xsr_cyc(cfg.xsr) - 1'b1;
    t_val         = '0;
    t_val[T_WR]   = clamp_cyc(cfg.wr)  - 1'b1;
    t_val[T_RC]   = clamp_cyc(cfg.rc)  - 1'b1;
    t_val[T_RP]   = clamp_cyc(cfg.rp)  - 1'b1;
    t_val[T_RCD]  = clamp_cyc(cfg.rcd) - 1'b1;
    t_val[T_RAS]  = clamp_cyc(cfg.ras) - 1'b1;
    t_val[T_XSR]  = W'(xsr_m1);
  end
endmodule

// File: rtl/sdram_cmd_interlock.sv
module sdram_cmd_interlock
  import sdi_pkg::*;
#(
  parameter int CFG_W = CFGW,
  parameter int N_TMR = NT,
  parameter int TW    = DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             cfg_err,
  output logic [1:0]       rd_latency,
  input  logic             req_valid,
  input  logic [2:0]       req_cmd,
  output logic             req_ready,
  output logic [2:0]       pin_cmd,
  output logic             pin_cke
);
  cfg_t                     cfg_q;
  logic                     issue;
  logic                     in_sr, sr_next;
  logic [N_TMR-1:0]         t_load, t_zero;
  logic [N_TMR-1:0][TW-1:0] t_val;
  cmd_e                     cmd;

  assign cmd = cmd_e'(req_cmd);

  sdi_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cfg_q(cfg_q), .cfg_err(cfg_err), .rd_latency(rd_latency)
  );

  sdi_gate #(.N(N_TMR), .W(TW)) u_gate (
    .req_valid(req_valid), .req_cmd(req_cmd), .in_sr(in_sr),
    .t_zero(t_zero), .cfg(cfg_q), .req_ready(req_ready),
    .issue(issue), .t_load(t_load), .t_val(t_val)
  );

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    sdi_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load[gi]),
      .load_val(t_val[gi]), .expired(t_zero[gi])
    );
  end

  always_comb begin
    sr_next = in_sr;
    if (issue && cmd == C_SRE)      sr_next = 1'b1;
    else if (issue && cmd == C_SRX) sr_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sr   <= 1'b0;
      pin_cmd <= PIN_NOP;
      pin_cke <= 1'b1;
    end else begin
      in_sr   <= sr_next;
      pin_cmd <= issue ? pin_code(cmd) : PIN_NOP;
      pin_cke <= !sr_next;
    end
  end
endmodule

// File: rtl/sdi_checker.sv
module sdi_checker
  import sdi_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_cmd,
  input logic [2:0]  pin_cmd,
  input logic        pin_cke,
  input logic        cfg_wr,
  input logic [26:0] cfg_word,
  input logic        cfg_err,
  input logic        issue,
  input logic        in_sr,
  input cfg_t        cfg_q
);
  logic [7:0] gap_act, gap_pre, gap_ref, gap_wr, gap_xsr;
  logic [4:0] need_rcd, need_ras, need_rp, need_rc, need_wr, need_xsr;
  logic is_act, is_rw, is_pre, is_ref, is_wr, is_srx_sr, is_gated_rp;

  function automatic logic [7:0] sat(input logic [7:0] g);
    return (g == 8'hFF) ? g : g + 1'b1;
  endfunction

  always_comb begin
    is_act      = issue && req_cmd == C_ACT;
    is_rw       = issue && (req_cmd == C_RD || req_cmd == C_WR);
    is_pre      = issue && req_cmd == C_PRE;
    is_ref      = issue && req_cmd == C_REF;
    is_wr       = issue && req_cmd == C_WR;
    is_srx_sr   = issue && req_cmd == C_SRX && in_sr;
    is_gated_rp = issue && req_cmd != C_NOP && req_cmd != C_SRX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_act <= 8'hFF; gap_pre <= 8'hFF; gap_ref <= 8'hFF;
      gap_wr  <= 8'hFF; gap_xsr <= 8'hFF;
      need_rcd <= '0; need_ras <= '0; need_rp <= '0;
      need_rc  <= '0; need_wr  <= '0; need_xsr <= '0;
    end else begin
      gap_act <= is_act    ? 8'd1 : sat(gap_act);
      gap_pre <= is_pre    ? 8'd1 : sat(gap_pre);
      gap_ref <= is_ref    ? 8'd1 : sat(gap_ref);
      gap_wr  <= is_wr     ? 8'd1 : sat(gap_wr);
      gap_xsr <= is_srx_sr ? 8'd1 : sat(gap_xsr);
      if (is_act) begin
        need_rcd <= {1'b0, clamp_cyc(cfg_q.rcd)};
        need_ras <= {1'b0, clamp_cyc(cfg_q.ras)};
      end
      if (is_pre)    need_rp  <= {1'b0, clamp_cyc(cfg_q.rp)};
      if (is_ref)    need_rc  <= {1'b0, clamp_cyc(cfg_q.rc)};
      if (is_wr)     need_wr  <= {1'b0, clamp_cyc(cfg_q.wr)};
      if (is_srx_sr) need_xsr <= xsr_cyc(cfg_q.xsr);
    end
  end

  a_r2_held_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> pin_cmd == PIN_NOP);
  // R3 and R8: activate-to-column spacing with floor of two
  a_r3_col_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> gap_act >= {3'b0, need_rcd});
  a_r4_pre_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> gap_act >= {3'b0, need_ras});
  a_r5_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    is_gated_rp |-> gap_pre >= {3'b0, need_rp});
  a_r6_act_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> gap_ref >= {3'b0, need_rc});
  a_r7_pre_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> gap_wr >= {3'b0, need_wr});
  a_r9_act_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> gap_xsr >= {3'b0, need_xsr});
  a_r10_sr_only_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !pin_cke) |-> (req_cmd == C_NOP || req_cmd == C_SRX));
  a_r10_cke_tracks_sr: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr != pin_cke);
  a_r11_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_word[26:25] != CAS_TWO) |=> cfg_err);
  a_r11_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_word[26:25] == CAS_TWO) |=> !cfg_err);
endmodule

bind sdram_cmd_interlock sdi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_cmd(req_cmd), .pin_cmd(pin_cmd), .pin_cke(pin_cke), .cfg_wr(cfg_wr),
  .cfg_word(cfg_word), .cfg_err(cfg_err), .issue(issue), .in_sr(in_sr),
  .cfg_q(cfg_q)
);

// File: tb/tb_sdram_cmd_interlock.sv
`timescale 1ns/1ps
module tb_sdram_cmd_interlock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [26:0] cfg_word = '0;
  logic        cfg_err;
  logic [1:0]  rd_latency;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = 3'd0;
  logic        req_ready;
  logic [2:0]  pin_cmd;
  logic        pin_cke;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdram_cmd_interlock dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cfg_err(cfg_err), .rd_latency(rd_latency), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_ready(req_ready), .pin_cmd(pin_cmd),
    .pin_cke(pin_cke)
  );

  localparam logic [2:0] NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4,
                         REF = 5, SRE = 6, SRX = 7;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int floor2(input int f);
    if (f <= 2) return 2;
    return f;
  endfunction

  function automatic int halfup(input int h);
    if (h == 0) return 1;
    return (h % 2 == 1) ? h / 2 + 1 : h / 2;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] pins_for(input logic [2:0] c);
    case (c)
      ACT: return 3'b011;
      RD:  return 3'b101;
      WR:  return 3'b100;
      PRE: return 3'b010;
      REF: return 3'b001;
      SRE: return 3'b001;
      default: return 3'b111;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] c);
    case (c)
      ACT: return "R6";
      RD, WR: return "R3";
      PRE: return "R4";
      REF, SRE: return "R5";
      default: return "R10";
    endcase
  endfunction

  // ---------------- reference model ----------------
  int cyc;
  int e_wr, e_rc, e_rp, e_rcd, e_ras, e_xsr;
  bit m_sr, m_err;
  int f_wr, f_rc, f_rp, f_rcd, f_ras, f_xsr;
  logic [2:0] exp_pin;
  bit exp_cke, have_exp, s_ok, s_acc, s_wr;
  logic [2:0] s_cmd;
  logic [26:0] s_word;

  function automatic bit model_ready(input logic [2:0] c);
    if (c == NOP || c == SRX) return 1'b1;
    if (m_sr) return 1'b0;
    case (c)
      ACT: return cyc >= e_rc && cyc >= e_rp && cyc >= e_xsr;
      RD, WR: return cyc >= e_rcd && cyc >= e_rp;
      PRE: return cyc >= e_ras && cyc >= e_wr && cyc >= e_rp;
      default: return cyc >= e_rp;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit r;
      if (have_exp) begin
        chk(pin_cmd == exp_pin, "R2 pin_cmd", int'(pin_cmd), int'(exp_pin));
        chk(pin_cke == exp_cke, "R10 pin_cke", int'(pin_cke), int'(exp_cke));
      end
      chk(cfg_err == m_err, "R11 cfg_err", int'(cfg_err), int'(m_err));
      chk(rd_latency == 2'd2, "R11 rd_latency", int'(rd_latency), 2);
      r = model_ready(req_cmd);
      chk(req_ready == r, tag_for(req_cmd), int'(req_ready), int'(r));
      s_acc = req_valid && r;
      s_cmd = req_cmd;
      s_wr = cfg_wr;
      s_word = cfg_word;
      s_ok = 1'b1;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; e_wr = 0; e_rc = 0; e_rp = 0; e_rcd = 0; e_ras = 0; e_xsr = 0;
      m_sr = 0; m_err = 0; have_exp = 0; s_ok = 0;
      f_wr = 2; f_rc = 8; f_rp = 3; f_rcd = 3; f_ras = 5; f_xsr = 10;
    end else if (s_ok) begin
      if (s_acc) begin
        case (s_cmd)
          ACT: begin
            e_rcd = mx(e_rcd, cyc + floor2(f_rcd));
            e_ras = mx(e_ras, cyc + floor2(f_ras));
          end
          WR:  e_wr = mx(e_wr, cyc + floor2(f_wr));
          PRE: e_rp = mx(e_rp, cyc + floor2(f_rp));
          REF: e_rc = mx(e_rc, cyc + floor2(f_rc));
          SRE: m_sr = 1;
          SRX: if (m_sr) begin m_sr = 0; e_xsr = mx(e_xsr, cyc + halfup(f_xsr)); end
          default: ;
        endcase
      end
      exp_pin = s_acc ? pins_for(s_cmd) : 3'b111;
      exp_cke = !m_sr;
      have_exp = 1;
      if (s_wr) begin
        f_wr = int'(s_word[3:0]);  f_rc = int'(s_word[7:4]);
        f_rp = int'(s_word[11:8]); f_rcd = int'(s_word[15:12]);
        f_ras = int'(s_word[19:16]); f_xsr = int'(s_word[24:20]);
        m_err = (s_word[26:25] != 2'b10);
      end
      cyc++;
      s_ok = 0;
    end
  end

  // ---------------- stimulus helpers (start at posedge + 1) ----------------
  task automatic idle(input int n);
    req_valid = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wcfg(input int wr, rc, rp, rcd, ras, xsr, input logic [1:0] cas);
    cfg_word = {cas, 5'(xsr), 4'(ras), 4'(rcd), 4'(rp), 4'(rc), 4'(wr)};
    cfg_wr = 1;
    @(posedge clk); #1;
    cfg_wr = 0;
  endtask

  task automatic gap(input logic [2:0] c, output int n);
    bit ok;
    n = 0;
    req_cmd = c;
    req_valid = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #1; n++;
      if (ok) break;
    end
    req_valid = 0;
  endtask

  task automatic issue(input logic [2:0] c);
    int n;
    gap(c, n);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    int g;
    int seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    req_cmd = ACT;
    @(negedge clk);
    chk(pin_cmd == 3'b111, "R1 reset pins", int'(pin_cmd), 7);
    chk(pin_cke == 1'b1, "R1 reset cke", int'(pin_cke), 1);
    chk(cfg_err == 1'b0, "R1 reset err", int'(cfg_err), 0);
    chk(rd_latency == 2'd2, "R1 reset latency", int'(rd_latency), 2);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    @(posedge clk); #1;

    // R1 default fields
    issue(ACT); gap(RD, g);  chk(g == 3, "R1 default act-col", g, 3);
    idle(20); issue(ACT); gap(PRE, g); chk(g == 5, "R1 default act-pre", g, 5);
    gap(ACT, g); chk(g == 3, "R5 default pre-act", g, 3);
    idle(20); issue(REF); gap(ACT, g); chk(g == 8, "R6 default ref-act", g, 8);
    idle(20); issue(SRE); issue(SRX); gap(ACT, g);
    chk(g == 5, "R1 default exit delay", g, 5);

    // R8 clamp
    wcfg(0, 1, 2, 0, 1, 10, 2'b10); idle(20);
    issue(ACT); gap(RD, g); chk(g == 2, "R8 act-col floor", g, 2);
    idle(20); issue(ACT); gap(PRE, g); chk(g == 2, "R8 act-pre floor", g, 2);
    gap(ACT, g); chk(g == 2, "R8 pre floor", g, 2);
    idle(20); issue(ACT); gap(WR, g); issue(PRE);
    idle(20); issue(REF); gap(ACT, g); chk(g == 2, "R8 ref-act floor", g, 2);
    idle(20); issue(WR); gap(PRE, g); chk(g == 2, "R8 write recovery floor", g, 2);

    // R3 maximum
    wcfg(2, 8, 3, 15, 5, 10, 2'b10); idle(20);
    issue(ACT); gap(WR, g); chk(g == 15, "R3 act-col 15", g, 15);

    // R7 write recovery
    wcfg(9, 8, 3, 3, 5, 10, 2'b10); idle(20);
    issue(ACT); gap(WR, g); chk(g == 3, "R3 act-write", g, 3);
    gap(PRE, g); chk(g == 9, "R7 write-pre", g, 9);

    // R12 overlap: older activate window dominates
    wcfg(3, 8, 3, 2, 12, 10, 2'b10); idle(20);
    issue(ACT); gap(WR, g); chk(g == 2, "R12 act-write", g, 2);
    gap(PRE, g); chk(g == 10, "R12 pre waits longest", g, 10);

    // R9 / R10 self-refresh
    wcfg(2, 8, 3, 3, 5, 3, 2'b10); idle(20);
    issue(SRE);
    @(negedge clk);
    chk(pin_cke == 1'b0, "R10 entry drops cke", int'(pin_cke), 0);
    chk(pin_cmd == 3'b001, "R10 entry pins", int'(pin_cmd), 1);
    @(posedge clk); #1;
    req_cmd = ACT; req_valid = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R10 activate held in self-refresh", int'(req_ready), 0);
      @(posedge clk); #1;
    end
    req_valid = 0;
    issue(SRX);
    @(negedge clk);
    chk(pin_cke == 1'b1, "R10 exit raises cke", int'(pin_cke), 1);
    @(posedge clk); #1;
    gap(ACT, g); chk(g == 1, "R9 exit h=3 after extra cycle", g, 1);
    idle(20); issue(SRE); issue(SRX); gap(ACT, g); chk(g == 2, "R9 exit h=3", g, 2);
    wcfg(2, 8, 3, 3, 5, 0, 2'b10); idle(20);
    issue(SRE); issue(SRX); gap(ACT, g); chk(g == 1, "R9 exit h=0", g, 1);
    wcfg(2, 8, 3, 3, 5, 31, 2'b10); idle(20);
    issue(SRE); issue(SRX); gap(ACT, g); chk(g == 16, "R9 exit h=31", g, 16);
    idle(20); issue(SRX);
    @(negedge clk);
    chk(pin_cmd == 3'b111 && pin_cke == 1'b1, "R10 stray exit no effect",
        int'({pin_cke, pin_cmd}), 15);
    @(posedge clk); #1;
    gap(ACT, g); chk(g == 1, "R10 stray exit starts no delay", g, 1);

    // R11 CAS code
    idle(20);
    wcfg(2, 8, 3, 6, 5, 10, 2'b11);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R11 reserved sets err", int'(cfg_err), 1);
    chk(rd_latency == 2'd2, "R11 latency kept", int'(rd_latency), 2);
    @(posedge clk); #1;
    issue(ACT); gap(RD, g); chk(g == 6, "R11 fields taken on reserved", g, 6);
    wcfg(2, 8, 3, 3, 5, 10, 2'b10);
    @(negedge clk);
    chk(cfg_err == 1'b0, "R11 valid clears err", int'(cfg_err), 0);
    @(posedge clk); #1;

    // random traffic checked by the model
    for (int i = 0; i < 4000; i++) begin
      req_valid = ($urandom % 10) < 7;
      req_cmd = 3'($urandom % 8);
      if (($urandom % 50) == 0) begin
        cfg_word = 27'($urandom);
        cfg_wr = 1;
      end else begin
        cfg_wr = 0;
      end
      @(posedge clk); #1;
    end
    req_valid = 0; cfg_wr = 0;
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule